// File: doc/BRIEF.md
# Tail-Biting Rate-1/3 Convolutional Encoder

This block encodes one finite block of data bits with a rate-1/3 convolutional code of constraint length 7. It produces three coded bits for every data bit and adds no flush bits, so a block of N bits yields exactly 3N coded bits. Before the first coded triple comes out, the six memory stages are loaded with the final six bits of that same block. The encoder therefore begins and ends in the same state. A receiver knows that the two states match, but it does not know what the state is.

A block is presented in parallel on a wide data port, together with its length and a one-cycle start strobe. The whole block is captured internally, because its tail is needed before its head can be encoded. In the following cycles the block emits one triple per accepted transfer, using a valid/ready handshake, and it flags the final triple with a last marker. A new block is accepted only while the encoder is idle.

Top module: `tbc_encoder`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: When `startIn` is high at a clock edge while `inReady` is 1 and `blkLen` is in 6..128, the block is captured. From the next cycle, `outValid` is 1 and `inReady` is 0.
- R3: Coded bit `outBits[g]` is the XOR of those bits of the 7-bit window {u(k), u(k-1), ..., u(k-6)} that are selected by generator g. The generators are 133, 171 and 165 octal for g = 0, 1 and 2. The generator MSB taps the current bit u(k). An all-ones block therefore gives `outBits` = 3'b111 on every triple.
- R4: Triple k encodes data bit k (bit 0 of `blkData` comes first). Earlier positions wrap around the block: u(k-j) for k < j is data bit N+k-j. As a result, the first triple already depends on data bits N-1 down to N-6.
- R5: Exactly `blkLen` triples are transferred. `outLast` is 1 only on the final one. In the cycle after that transfer, `outValid` is 0 and `inReady` is 1.
- R6: While `outValid` is 1 and `outReady` is 0, the presented triple and `outLast` hold unchanged into the next cycle.
- R7: A `startIn` pulse while a block is being emitted is ignored. Any change on `blkData` or `blkLen` during emission is also ignored, and the triples in flight are unaffected.
- R8: A `startIn` pulse with `blkLen` outside 6..128 is ignored: no triple appears and `inReady` stays 1.
- R9: Bits of `blkData` at positions `blkLen` and above have no effect on the coded output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | One-cycle request to capture a block |
| blkLen | input | 8 | Block length in bits, valid range 6..128 |
| blkData | input | 128 | Block bits, bit 0 encoded first |
| inReady | output | 1 | Encoder idle, a start will be accepted |
| outReady | input | 1 | Downstream accepts the presented triple |
| outBits | output | 3 | Coded triple, bit g from generator g |
| outValid | output | 1 | A triple is presented |
| outLast | output | 1 | Presented triple is the final one of the block |

## Verification
The hardest condition to reach from the ports is the wrap-around of the encoder memory. Its effect is visible only in the first six triples, and only when the block tail differs from zeros. The stimulus places a single one at the last position of a block, and it also uses the shortest legal length of six, where every triple depends on wrapped bits. A second hard case is a stall on the final triple combined with a start pulse during emission. A periodic `outReady` pattern and a start strobe fired mid-block drive the encoder into these states.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int CONSTRAINT_LEN = 7;
  localparam int MEM_BITS = CONSTRAINT_LEN - 1;

  typedef struct packed {
    logic load;     // capture block and preload memory
    logic advance;  // triple transferred, shift one bit
  } tbcStrobe_t;
endpackage

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int MAX_LEN = 128,
  parameter int MIN_LEN = MEM_BITS,
  parameter int LEN_W   = $clog2(MAX_LEN) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] blkLen,
  input  logic             outReady,
  output tbcStrobe_t       strobe,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast
);
  logic             busy;
  logic [LEN_W-1:0] remain;
  logic             lenOk;

  assign lenOk = (blkLen >= LEN_W'(MIN_LEN)) && (blkLen <= LEN_W'(MAX_LEN));

  always_comb begin
    strobe.load    = startIn && !busy && lenOk;
    strobe.advance = busy && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      remain <= blkLen;
    end else if (strobe.advance) begin
      if (remain == LEN_W'(1)) busy <= 1'b0;
      remain <= remain - LEN_W'(1);
    end
  end

  assign inReady  = !busy;
  assign outValid = busy;
  assign outLast  = busy && (remain == LEN_W'(1));
endmodule

// File: rtl/tbc_dp.sv
module tbc_dp
  import tbc_pkg::*;
#(
  parameter int          MAX_LEN = 128,
  parameter int          LEN_W   = $clog2(MAX_LEN) + 1,
  parameter logic [6:0]  GEN0    = 7'o133,
  parameter logic [6:0]  GEN1    = 7'o171,
  parameter logic [6:0]  GEN2    = 7'o165
) (
  input  logic               clk,
  input  logic               rstN,
  input  tbcStrobe_t         strobe,
  input  logic [MAX_LEN-1:0] blkData,
  input  logic [LEN_W-1:0]   blkLen,
  output logic [2:0]         outBits
);
  localparam logic [2:0][6:0] GENS = {GEN2, GEN1, GEN0};

  logic [MAX_LEN-1:0]  dataReg;
  logic [MEM_BITS-1:0] mem;      // mem[MEM_BITS-1] newest, mem[0] deepest
  logic [MEM_BITS-1:0] preload;
  logic [CONSTRAINT_LEN-1:0] window;

  // memory stage (6-j) takes block bit N-j
  always_comb begin
    for (int j = 1; j <= MEM_BITS; j++) begin
      logic [MAX_LEN-1:0] shifted;
      shifted = blkData >> (blkLen - LEN_W'(j));
      preload[MEM_BITS-j] = shifted[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      mem     <= '0;
    end else if (strobe.load) begin
      dataReg <= blkData;
      mem     <= preload;
    end else if (strobe.advance) begin
      dataReg <= dataReg >> 1;
      mem     <= {dataReg[0], mem[MEM_BITS-1:1]};
    end
  end

  assign window = {dataReg[0], mem};

  for (genvar g = 0; g < 3; g++) begin : gStream
    assign outBits[g] = ^(window & GENS[g]);
  end
endmodule

// File: rtl/tbc_encoder.sv
module tbc_encoder
  import tbc_pkg::*;
#(
  parameter int         MAX_LEN = 128,
  parameter int         MIN_LEN = MEM_BITS,
  parameter int         LEN_W   = $clog2(MAX_LEN) + 1,
  parameter logic [6:0] GEN0    = 7'o133,
  parameter logic [6:0] GEN1    = 7'o171,
  parameter logic [6:0] GEN2    = 7'o165
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [LEN_W-1:0]   blkLen,
  input  logic [MAX_LEN-1:0] blkData,
  output logic               inReady,
  input  logic               outReady,
  output logic [2:0]         outBits,
  output logic               outValid,
  output logic               outLast
);
  tbcStrobe_t strobe;

  tbc_ctrl #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .blkLen(blkLen),
    .outReady(outReady), .strobe(strobe), .inReady(inReady),
    .outValid(outValid), .outLast(outLast)
  );

  tbc_dp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
           .GEN0(GEN0), .GEN1(GEN1), .GEN2(GEN2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkData(blkData),
    .blkLen(blkLen), .outBits(outBits)
  );
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker #(
  parameter int MAX_LEN = 128,
  parameter int MIN_LEN = 6,
  parameter int LEN_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               startIn,
  input logic [LEN_W-1:0]   blkLen,
  input logic [MAX_LEN-1:0] blkData,
  input logic               inReady,
  input logic               outReady,
  input logic [2:0]         outBits,
  input logic               outValid,
  input logic               outLast
);
  logic             accept;
  logic [LEN_W-1:0] lenHeld;
  logic [LEN_W-1:0] beats;

  assign accept = startIn && inReady &&
                  (blkLen >= LEN_W'(MIN_LEN)) && (blkLen <= LEN_W'(MAX_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenHeld <= '0;
      beats   <= '0;
    end else if (accept) begin
      lenHeld <= blkLen;
      beats   <= '0;
    end else if (outValid && outReady) begin
      beats <= beats + LEN_W'(1);
    end
  end

  assert_idle_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_start_emits_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (outValid && !inReady));

  assert_last_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |-> (beats + LEN_W'(1) == lenHeld));

  assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBits) && $stable(outLast)));

  assert_bad_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && inReady && !accept) |=> (inReady && !outValid));

  logic unusedData;
  assign unusedData = ^blkData;
endmodule

bind tbc_encoder tbc_checker #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_tbc_encoder.sv
`timescale 1ns/1ps
module sim_tbc_encoder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [7:0]   blkLen = '0;
  logic [127:0] blkData = '0;
  logic         inReady;
  logic         outReady = 1'b0;
  logic [2:0]   outBits;
  logic         outValid;
  logic         outLast;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  tbc_encoder u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .blkLen(blkLen),
    .blkData(blkData), .inReady(inReady), .outReady(outReady),
    .outBits(outBits), .outValid(outValid), .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] refTriple(input logic [127:0] d, input int n, input int k);
    logic [6:0] w;
    for (int j = 0; j <= 6; j++) w[6-j] = d[(k - j + n) % n];
    return {^(w & 7'o165), ^(w & 7'o171), ^(w & 7'o133)};
  endfunction

  // stallMode: 1 = outReady low every third cycle; poke: fire a start mid-block
  task automatic runBlock(input int len, input logic [127:0] d, input bit stallMode,
                          input bit poke, input string tag);
    int k = 0;
    bit held = 0;
    logic [2:0] prevBits = '0;
    logic prevLast = 0;
    @(negedge clk);
    startIn = 1'b1; blkLen = 8'(len); blkData = d; outReady = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(outValid && !inReady, {tag, " R2 start"}, {outValid, inReady}, 2);
    for (int cyc = 0; cyc < 4 * len + 10; cyc++) begin
      if (cyc > 0) @(negedge clk);
      startIn = 1'b0;
      if (poke && cyc == 2) begin
        startIn = 1'b1; blkLen = 8'd6; blkData = ~d;
      end
      outReady = stallMode ? ((cyc % 3) != 1) : 1'b1;
      if (!outValid) begin
        check(0, {tag, " R5 early end"}, k, len);
        break;
      end
      if (held) check(outBits == prevBits && outLast == prevLast, {tag, " R6 hold"},
                      {outBits, outLast}, {prevBits, prevLast});
      check(outBits == refTriple(d, len, k), {tag, poke ? " R7 triple" : " R3/R4 triple"},
            outBits, refTriple(d, len, k));
      check(outLast == (k == len - 1), {tag, " R5 last"}, outLast, k == len - 1);
      held = !outReady; prevBits = outBits; prevLast = outLast;
      if (outReady) begin
        k++;
        if (k == len) break;
      end
    end
    startIn = 1'b0;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid && inReady, {tag, " R5 idle after"}, {outValid, inReady}, 1);
  endtask

  task automatic badLen(input int len);
    @(negedge clk);
    startIn = 1'b1; blkLen = 8'(len); blkData = '1; outReady = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (2) begin
      check(!outValid && inReady, "R8 bad length ignored", {outValid, inReady}, 1);
      @(negedge clk);
    end
  endtask

  task automatic allOnes();
    @(negedge clk);
    startIn = 1'b1; blkLen = 8'd17; blkData = '1; outReady = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 0; k < 17; k++) begin
      check(outValid && outBits == 3'b111, "R3 all ones", outBits, 7);
      @(negedge clk);
    end
    check(!outValid, "R5 all ones end", outValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    #1;
    check(!outValid && inReady, "R1 reset state", {outValid, inReady}, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && inReady, "R1 after reset", {outValid, inReady}, 1);

    runBlock(6, 128'b101100, 0, 0, "len6 wrap");
    runBlock(20, 128'h1 << 19, 0, 0, "tail impulse");
    runBlock(20, 128'h1, 1, 0, "head impulse stall");
    pat = '0;
    for (int i = 0; i < 128; i++) pat[i] = ((i * 7 + 3) % 5) < 2;
    runBlock(128, pat, 1, 0, "len128 stall");
    runBlock(40, {88'hDEAD_BEEF_F00D_CAFE_1234_5, 40'hAA_5555_AAAA}, 0, 0, "R9 upper garbage");
    runBlock(10, 128'h2B7, 0, 1, "start while busy");
    allOnes();
    badLen(5);
    badLen(129);
    badLen(0);
    runBlock(6, 128'b011111, 1, 0, "len6 stall");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule